// File: doc/BRIEF.md
# Execution Start Address Validator

This block decides whether a coprocessor is permitted to begin fetching at a requested program location, given an 8-bit bank number and a 16-bit program counter. The bank space is split into unused holes, a RAM region and a ROM region. A RAM start needs the RAM-enable bit and a ROM start needs the ROM-enable bit. An active instruction cache whose 512-byte window covers the program counter overrides every bank rule.

Each start request is sampled on a clock edge. One cycle later the block presents a registered verdict, a one-cycle done strobe, and, for a refused start, a one-cycle strobe that tells the sequencer to clear its running flag. The block also registers a step-over target: the program counter advanced by the length of the instruction whose opcode byte is at the head of the pipe. The owner uses this target for single-step-over.

Top module: `start_validator`

## Requirements
- R1: When cache_act_i is 1 and cache_base_i <= pc_i < cache_base_i + 512, the start is allowed. This holds for any bank and for any enable bits.
- R2: The cache window is compared in 17-bit arithmetic and does not wrap. With base 0xFF00, pc 0xFFFF is inside the window and pc 0x0010 is outside it.
- R3: With no cache hit, a bank below 0x40 with pc below 0x8000 is rejected. A bank below 0x40 with pc at or above 0x8000 is treated as ROM.
- R4: With no cache hit, banks 0x60 to 0x6F and every bank at or above 0x74 are rejected, whatever the enable bits are.
- R5: With no cache hit, banks 0x70 to 0x73 are allowed only when ram_en_i is 1.
- R6: With no cache hit, every remaining bank is allowed only when rom_en_i is 1.
- R7: A request sampled at edge N drives done_o high after edge N for exactly one cycle. The allow_o verdict is updated at that same edge.
- R8: clr_go_o pulses together with done_o exactly when the start is rejected, and stays low when the start is allowed.
- R9: step_tgt_o is pc+3 for opcodes 0xF0 to 0xFF, pc+2 for opcodes 0x05 to 0x0F and 0xA0 to 0xAF, and pc+1 for all other opcodes.
- R10: The step target wraps modulo 2^16.
- R11: After reset, done_o, clr_go_o and allow_o are 0 and step_tgt_o is 0.
- R12: allow_o and step_tgt_o hold their values while no request is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request, sampled on the rising edge |
| bank_i | input | 8 | Program bank |
| pc_i | input | 16 | Program counter |
| rom_en_i | input | 1 | ROM region enable |
| ram_en_i | input | 1 | RAM region enable |
| cache_act_i | input | 1 | Instruction cache active |
| cache_base_i | input | 16 | Cache window base address |
| opcode_i | input | 8 | Opcode byte at the pipe head |
| done_o | output | 1 | Verdict valid strobe |
| allow_o | output | 1 | Start allowed (held) |
| clr_go_o | output | 1 | Clear-running strobe on rejection |
| step_tgt_o | output | 16 | Step-over target address (held) |

## Verification
The hardest case to reach is a cache hit near the top of the address space, where only 17-bit arithmetic separates a real hit from a false wrap. The bench sets the base to 0xFF00 and probes pc 0xFFFF and pc 0x0010 from a hole bank with both enables off. The two probes can only differ in the cache term, so any wrap error changes the verdict. Each bank boundary is probed on both sides, and every enable is toggled, so that each region rule is isolated.

// File: rtl/start_validator_pkg.sv
package start_validator_pkg;
  typedef enum logic [1:0] {
    REG_HOLE = 2'd0,
    REG_RAM  = 2'd1,
    REG_ROM  = 2'd2
  } region_e;

  localparam int unsigned BANK_W     = 8;
  localparam int unsigned ADDR_W     = 16;
  localparam int unsigned OP_W       = 8;
  localparam int unsigned WIN_BYTES  = 512;
endpackage

// File: rtl/bank_region_decode.sv
module bank_region_decode
  import start_validator_pkg::*;
#(
  parameter int unsigned BW          = BANK_W,
  parameter int unsigned AW          = ADDR_W,
  parameter logic [BW-1:0] LOW_BANK_TOP = 8'h40,
  parameter logic [AW-1:0] LOW_PC_TOP   = 16'h8000,
  parameter logic [BW-1:0] HOLE_LO      = 8'h60,
  parameter logic [BW-1:0] HOLE_HI      = 8'h6F,
  parameter logic [BW-1:0] RAM_LO       = 8'h70,
  parameter logic [BW-1:0] RAM_HI       = 8'h73
) (
  input  logic [BW-1:0] bank_i,
  input  logic [AW-1:0] pc_i,
  output region_e       region_o
);
  logic low_hole, mid_hole, high_hole, in_ram;

  always_comb begin
    low_hole  = (bank_i < LOW_BANK_TOP) && (pc_i < LOW_PC_TOP);
    mid_hole  = (bank_i >= HOLE_LO) && (bank_i <= HOLE_HI);
    high_hole = (bank_i > RAM_HI);
    in_ram    = (bank_i >= RAM_LO) && (bank_i <= RAM_HI);
    if (low_hole || mid_hole || high_hole) region_o = REG_HOLE;
    else if (in_ram)                       region_o = REG_RAM;
    else                                   region_o = REG_ROM;
  end
endmodule

// File: rtl/cache_window_check.sv
module cache_window_check #(
  parameter int unsigned AW    = 16,
  parameter int unsigned BYTES = 512
) (
  input  logic          act_i,
  input  logic [AW-1:0] base_i,
  input  logic [AW-1:0] pc_i,
  output logic          hit_o
);
  localparam int unsigned EW = AW + 1;
  localparam logic [EW-1:0] SPAN = EW'(BYTES);

  logic [EW-1:0] lo_x, hi_x, pc_x;

  always_comb begin
    lo_x  = {1'b0, base_i};
    hi_x  = lo_x + SPAN;          // extra bit: no false wrap near top
    pc_x  = {1'b0, pc_i};
    hit_o = act_i && (pc_x >= lo_x) && (pc_x < hi_x);
  end
endmodule

// File: rtl/step_len_decode.sv
module step_len_decode #(
  parameter int unsigned AW = 16,
  parameter int unsigned OW = 8
) (
  input  logic [OW-1:0] op_i,
  input  logic [AW-1:0] pc_i,
  output logic [AW-1:0] tgt_o
);
  logic [1:0] len;

  always_comb begin
    if (op_i >= OW'(8'hF0))
      len = 2'd3;
    else if ((op_i >= OW'(8'h05) && op_i <= OW'(8'h0F)) ||
             (op_i >= OW'(8'hA0) && op_i <= OW'(8'hAF)))
      len = 2'd2;
    else
      len = 2'd1;
    tgt_o = pc_i + AW'(len);      // modulo 2^AW
  end
endmodule

// File: rtl/start_validator.sv
module start_validator
  import start_validator_pkg::*;
#(
  parameter int unsigned BW = BANK_W,
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned OW = OP_W,
  parameter int unsigned WB = WIN_BYTES
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [BW-1:0] bank_i,
  input  logic [AW-1:0] pc_i,
  input  logic          rom_en_i,
  input  logic          ram_en_i,
  input  logic          cache_act_i,
  input  logic [AW-1:0] cache_base_i,
  input  logic [OW-1:0] opcode_i,
  output logic          done_o,
  output logic          allow_o,
  output logic          clr_go_o,
  output logic [AW-1:0] step_tgt_o
);
  region_e       region;
  logic          cache_hit;
  logic [AW-1:0] tgt_d;
  logic          ok_d;

  bank_region_decode #(.BW(BW), .AW(AW)) u_region (
    .bank_i  (bank_i),
    .pc_i    (pc_i),
    .region_o(region)
  );

  cache_window_check #(.AW(AW), .BYTES(WB)) u_cache (
    .act_i (cache_act_i),
    .base_i(cache_base_i),
    .pc_i  (pc_i),
    .hit_o (cache_hit)
  );

  step_len_decode #(.AW(AW), .OW(OW)) u_step (
    .op_i (opcode_i),
    .pc_i (pc_i),
    .tgt_o(tgt_d)
  );

  always_comb begin
    unique case (region)
      REG_RAM: ok_d = ram_en_i;
      REG_ROM: ok_d = rom_en_i;
      default: ok_d = 1'b0;
    endcase
    if (cache_hit) ok_d = 1'b1;   // cache window wins
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o     <= 1'b0;
      clr_go_o   <= 1'b0;
      allow_o    <= 1'b0;
      step_tgt_o <= '0;
    end else begin
      done_o   <= start_i;
      clr_go_o <= start_i && !ok_d;
      if (start_i) begin
        allow_o    <= ok_d;
        step_tgt_o <= tgt_d;
      end
    end
  end

  assert_done_follows_start_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> done_o);
  assert_done_one_cycle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> !done_o);
  assert_clr_on_reject_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_go_o |-> (done_o && !allow_o));
  assert_no_clr_on_allow_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && allow_o) |-> !clr_go_o);
  assert_cache_override_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && cache_hit) |=> allow_o);
  assert_hole_reject_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !cache_act_i && (bank_i > BW'(8'h73))) |=> clr_go_o);
  assert_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> ($stable(allow_o) && $stable(step_tgt_o)));
  assert_step_range_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> ((step_tgt_o - $past(pc_i)) >= AW'(1) && (step_tgt_o - $past(pc_i)) <= AW'(3)));
endmodule

// File: tb/tb_start_validator.sv
module tb_start_validator;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  bank = '0;
  logic [15:0] pc = '0;
  logic        rom_en = 1'b0, ram_en = 1'b0, c_act = 1'b0;
  logic [15:0] c_base = '0;
  logic [7:0]  op = '0;
  logic        done, allow, clr_go;
  logic [15:0] tgt;

  int checks = 0;
  int fails  = 0;
  bit wd_hit = 1'b0;

  always #4 clk = ~clk;

  start_validator dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .bank_i(bank), .pc_i(pc),
    .rom_en_i(rom_en), .ram_en_i(ram_en), .cache_act_i(c_act),
    .cache_base_i(c_base), .opcode_i(op), .done_o(done), .allow_o(allow),
    .clr_go_o(clr_go), .step_tgt_o(tgt)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one request: drive at negedge, verdict after next posedge, strobe gone a cycle later
  task automatic req(input string tag, input logic [7:0] b, input logic [15:0] p,
                     input logic re, input logic ae, input logic ca, input logic [15:0] cb,
                     input logic [7:0] o, input logic exp_ok, input logic [15:0] exp_t);
    @(negedge clk);
    bank = b; pc = p; rom_en = re; ram_en = ae; c_act = ca; c_base = cb; op = o;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk({tag, " R7 done"}, {31'd0, done}, 32'd1);
    chk({tag, " allow"}, {31'd0, allow}, {31'd0, exp_ok});
    chk({tag, " R8 clr_go"}, {31'd0, clr_go}, {31'd0, !exp_ok});
    chk({tag, " step"}, {16'd0, tgt}, {16'd0, exp_t});
    @(negedge clk);
    chk({tag, " R7 done low"}, {31'd0, done}, 32'd0);
    chk({tag, " R8 clr low"}, {31'd0, clr_go}, 32'd0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R11 done", {31'd0, done}, 32'd0);
    chk("R11 allow", {31'd0, allow}, 32'd0);
    chk("R11 clr", {31'd0, clr_go}, 32'd0);
    chk("R11 tgt", {16'd0, tgt}, 32'd0);
  endtask

  task automatic t_cache();
    req("R1 hole bank hit", 8'h65, 16'h1234, 1'b0, 1'b0, 1'b1, 16'h1200, 8'h00, 1'b1, 16'h1235);
    req("R1 end of window", 8'h80, 16'h13FF, 1'b0, 1'b0, 1'b1, 16'h1200, 8'h00, 1'b1, 16'h1400);
    req("R1 past window", 8'h80, 16'h1400, 1'b0, 1'b0, 1'b1, 16'h1200, 8'h00, 1'b0, 16'h1401);
    req("R1 inactive", 8'h65, 16'h1234, 1'b1, 1'b1, 1'b0, 16'h1200, 8'h00, 1'b0, 16'h1235);
    req("R2 top hit", 8'h65, 16'hFFFF, 1'b0, 1'b0, 1'b1, 16'hFF00, 8'h00, 1'b1, 16'h0000);
    req("R2 no wrap", 8'h65, 16'h0010, 1'b0, 1'b0, 1'b1, 16'hFF00, 8'h00, 1'b0, 16'h0011);
  endtask

  task automatic t_banks();
    req("R3 low hole", 8'h3F, 16'h7FFF, 1'b1, 1'b1, 1'b0, 16'h0, 8'h00, 1'b0, 16'h8000);
    req("R3 low rom", 8'h00, 16'h8000, 1'b1, 1'b0, 1'b0, 16'h0, 8'h00, 1'b1, 16'h8001);
    req("R4 hole 60", 8'h60, 16'h8000, 1'b1, 1'b1, 1'b0, 16'h0, 8'h00, 1'b0, 16'h8001);
    req("R4 hole 6F", 8'h6F, 16'h8000, 1'b1, 1'b1, 1'b0, 16'h0, 8'h00, 1'b0, 16'h8001);
    req("R4 bank 74", 8'h74, 16'h8000, 1'b1, 1'b1, 1'b0, 16'h0, 8'h00, 1'b0, 16'h8001);
    req("R4 bank FF", 8'hFF, 16'h0000, 1'b1, 1'b1, 1'b0, 16'h0, 8'h00, 1'b0, 16'h0001);
    req("R5 ram on", 8'h70, 16'h0000, 1'b0, 1'b1, 1'b0, 16'h0, 8'h00, 1'b1, 16'h0001);
    req("R5 ram 73 on", 8'h73, 16'h0100, 1'b0, 1'b1, 1'b0, 16'h0, 8'h00, 1'b1, 16'h0101);
    req("R5 ram off", 8'h71, 16'h0100, 1'b1, 1'b0, 1'b0, 16'h0, 8'h00, 1'b0, 16'h0101);
    req("R6 rom 40 on", 8'h40, 16'h0000, 1'b1, 1'b0, 1'b0, 16'h0, 8'h00, 1'b1, 16'h0001);
    req("R6 rom 5F off", 8'h5F, 16'h0000, 1'b0, 1'b1, 1'b0, 16'h0, 8'h00, 1'b0, 16'h0001);
  endtask

  task automatic t_step();
    req("R9 op F0", 8'h40, 16'h2000, 1'b1, 1'b0, 1'b0, 16'h0, 8'hF0, 1'b1, 16'h2003);
    req("R9 op 05", 8'h40, 16'h2000, 1'b1, 1'b0, 1'b0, 16'h0, 8'h05, 1'b1, 16'h2002);
    req("R9 op 0F", 8'h40, 16'h2000, 1'b1, 1'b0, 1'b0, 16'h0, 8'h0F, 1'b1, 16'h2002);
    req("R9 op 04", 8'h40, 16'h2000, 1'b1, 1'b0, 1'b0, 16'h0, 8'h04, 1'b1, 16'h2001);
    req("R9 op AF", 8'h40, 16'h2000, 1'b1, 1'b0, 1'b0, 16'h0, 8'hAF, 1'b1, 16'h2002);
    req("R9 op B0", 8'h40, 16'h2000, 1'b1, 1'b0, 1'b0, 16'h0, 8'hB0, 1'b1, 16'h2001);
    req("R10 wrap", 8'h40, 16'hFFFE, 1'b1, 1'b0, 1'b0, 16'h0, 8'hFF, 1'b1, 16'h0001);
  endtask

  task automatic t_hold();
    req("R12 setup", 8'h72, 16'h4444, 1'b0, 1'b1, 1'b0, 16'h0, 8'hA0, 1'b1, 16'h4446);
    @(negedge clk);
    bank = 8'hFF; pc = 16'h0000; op = 8'hF5; ram_en = 1'b0;
    repeat (3) @(negedge clk);
    chk("R12 allow held", {31'd0, allow}, 32'd1);
    chk("R12 tgt held", {16'd0, tgt}, 32'h4446);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_reset();
    t_cache();
    t_banks();
    t_step();
    t_hold();
    if (!wd_hit) begin
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #200000;
    wd_hit = 1'b1;
    checks++;
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule